// File: doc/BRIEF.md
# Interrupt Redirection Register Window

This block holds the software-visible register file of an I/O interrupt controller. Software reaches it through two directly addressed 32-bit registers. One holds an 8-bit index. The other is a data window, and it reaches whichever internal register the index names. Those internal registers are a version word, an identification word, an arbitration word, and a table of 64-bit redirection entries with one entry per interrupt pin. Each entry is read and written as two 32-bit halves.

The block owns the redirection table and shows all of it on a flat output bus for the delivery logic next to it. Two bits in each entry belong to hardware: the remote-IRR bit and the delivery-status bit. Software writes cannot change them. A neighbour sets and clears remote IRR through strobes, and delivery status follows a busy input. Every table write is checked for side effects:
- A change of mask produces a one-cycle notification pulse.
- A level-triggered entry whose pin has a pending request produces a one-cycle service request.
- An entry left edge-triggered has its remote IRR dropped.

Delivery and end-of-interrupt processing live outside this block.

Top module: `irq_regwin`

## Requirements
- R1: A write at bus offset 0x00 loads bits 7:0 of the write data into the 8-bit index register. A read at offset 0x00 returns the index zero-extended to 32 bits.
- R2: A window read (offset 0x10) with index 0x01 returns the pin count minus one in bits 23:16 and the version code (default 0x11) in bits 7:0, with all other bits zero. Window writes with index 0x01 change nothing.
- R3: Window reads with index 0x00 or 0x02 return the 4-bit ID in bits 27:24 and zero elsewhere. A window write with index 0x00 loads data bits 27:24 into the ID. A window write with index 0x02 changes nothing.
- R4: Index values 0x10 and up select table entry (index − 0x10) >> 1. An even index reaches entry bits 31:0 and an odd index reaches bits 63:32. A window write replaces only that half, and a window read returns it.
- R5: A window read whose index names no existing entry returns 0xFFFFFFFF. This covers index 0x03 to 0x0F and entries at or beyond the pin count. A window write to such an index changes no state and produces no pulse.
- R6: Entry bit 14 (remote IRR) and bit 12 (delivery status) keep their hardware-owned values across any table write, whatever the written data.
- R7: When a table write leaves entry bit 15 (trigger mode, 1 = level) at 0, the entry's remote IRR becomes 0.
- R8: When a table write changes entry bit 16 (mask), `maskChgValid` is high for one cycle, with `maskChgPin` giving the entry number and `maskChgValue` the new mask. A write that keeps the mask produces no pulse.
- R9: When a table write leaves the entry level-triggered and `pinRequest` for that pin is high, `serviceValid` is high for one cycle with `servicePin` giving the pin. No pulse occurs otherwise.
- R10: After reset, every entry reads 0x00010000 in its low half and 0 in its high half (mask set), the index and ID are zero, and no pulse is active.
- R11: Reads at bus offsets other than 0x00 and 0x10 return zero, and writes at those offsets change nothing.
- R12: `busRdData` is updated one cycle after a cycle with `busRdEn` high, and holds its value while `busRdEn` is low.
- R13: On cycles with no table write to the entry, a `remIrrSet` strobe sets that entry's remote IRR and a `remIrrClr` strobe clears it. Delivery status follows `dlvBusy` with one cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| busWrEn | input | 1 | Bus write strobe |
| busRdEn | input | 1 | Bus read strobe |
| busAddr | input | 8 | Bus offset |
| busWrData | input | 32 | Bus write data |
| busRdData | output | 32 | Registered read data |
| pinRequest | input | PINS | Request level per pin, from the delivery logic |
| remIrrSet | input | PINS | Remote-IRR set strobes from hardware |
| remIrrClr | input | PINS | Remote-IRR clear strobes from hardware |
| dlvBusy | input | PINS | Delivery-status source per pin |
| tableFlat | output | PINS*64 | All entries; entry n sits at bits 64n+63:64n |
| maskChgValid | output | 1 | Mask-change pulse |
| maskChgPin | output | IDX_W | Pin whose mask changed |
| maskChgValue | output | 1 | New mask value |
| serviceValid | output | 1 | Service-request pulse |
| servicePin | output | IDX_W | Pin to service |

## Verification
Every result appears one clock edge after its stimulus:
- Read data is registered on the edge that samples `busRdEn`.
- Index, ID and table writes land on the edge that samples `busWrEn`. The mask-change and service pulses go high on that same edge and last exactly one cycle.
- Hardware strobes and `dlvBusy` reach the table on the next edge.

The bench drives every input on a falling edge and samples on the following falling edge. That is half a cycle after the only rising edge that can change the result. This lets it confirm both a pulse's presence and its absence after each write.

// File: rtl/irq_regwin_pkg.sv
`timescale 1ns/1ps
package irq_regwin_pkg;
  localparam int unsigned SEL_W  = 8;
  localparam int unsigned TIDX_W = SEL_W - 1;

  localparam logic [7:0] OFF_SEL = 8'h00;
  localparam logic [7:0] OFF_WIN = 8'h10;

  localparam logic [SEL_W-1:0] WIN_ID   = 8'h00;
  localparam logic [SEL_W-1:0] WIN_VER  = 8'h01;
  localparam logic [SEL_W-1:0] WIN_ARB  = 8'h02;
  localparam logic [SEL_W-1:0] WIN_TBL0 = 8'h10;

  localparam int unsigned BIT_DLV  = 12;
  localparam int unsigned BIT_RIRR = 14;
  localparam int unsigned BIT_TRIG = 15;
  localparam int unsigned BIT_MASK = 16;

  localparam logic [63:0] ENTRY_RESET = 64'h1 << BIT_MASK;

  typedef enum logic [2:0] {
    RD_ZERO, RD_SEL, RD_VER, RD_ID, RD_TBL, RD_ONES
  } rdKind_e;

  typedef struct packed {
    logic              selWr;
    logic              idWr;
    logic              tblWr;
    logic              tblHi;
    logic [TIDX_W-1:0] tblIdx;
    logic              rdLatch;
    rdKind_e           rdKind;
  } strobes_t;
endpackage

// File: rtl/irq_regwin_ctrl.sv
`timescale 1ns/1ps
module irq_regwin_ctrl
  import irq_regwin_pkg::*;
#(
  parameter int unsigned PINS = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busWrEn,
  input  logic             busRdEn,
  input  logic [7:0]       busAddr,
  input  logic [SEL_W-1:0] selReg,
  output strobes_t         strb
);
  logic             atSel;
  logic             atWin;
  logic [SEL_W-1:0] selOff;
  logic [TIDX_W-1:0] entryNum;
  logic             entryOk;

  assign atSel    = (busAddr == OFF_SEL);
  assign atWin    = (busAddr == OFF_WIN);
  assign selOff   = selReg - WIN_TBL0;
  assign entryNum = selOff[SEL_W-1:1];
  assign entryOk  = (selReg >= WIN_TBL0) && (32'(entryNum) < PINS);

  always_comb begin
    strb.selWr   = busWrEn && atSel;
    strb.idWr    = busWrEn && atWin && (selReg == WIN_ID);
    strb.tblWr   = busWrEn && atWin && entryOk;
    strb.tblHi   = selReg[0];
    strb.tblIdx  = entryNum;
    strb.rdLatch = busRdEn;
    if (atSel) begin
      strb.rdKind = RD_SEL;
    end else if (atWin) begin
      if (selReg == WIN_VER)                           strb.rdKind = RD_VER;
      else if (selReg == WIN_ID || selReg == WIN_ARB)  strb.rdKind = RD_ID;
      else if (entryOk)                                strb.rdKind = RD_TBL;
      else                                             strb.rdKind = RD_ONES;
    end else begin
      strb.rdKind = RD_ZERO;
    end
  end

  // R11: writes away from the two live offsets raise no write strobe
  assert_stray_write_R11: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr != OFF_SEL && busAddr != OFF_WIN) |-> !(strb.selWr || strb.idWr || strb.tblWr));

  // R5: a table write strobe only ever names an existing entry
  assert_tbl_in_range_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.tblWr |-> (32'(strb.tblIdx) < PINS));
endmodule

// File: rtl/irq_regwin_dp.sv
`timescale 1ns/1ps
module irq_regwin_dp
  import irq_regwin_pkg::*;
#(
  parameter int unsigned PINS    = 24,
  parameter logic [7:0]  VERSION = 8'h11,
  localparam int unsigned IDX_W  = (PINS > 1) ? $clog2(PINS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic [31:0]       busWrData,
  input  logic [PINS-1:0]   pinRequest,
  input  logic [PINS-1:0]   remIrrSet,
  input  logic [PINS-1:0]   remIrrClr,
  input  logic [PINS-1:0]   dlvBusy,
  output logic [SEL_W-1:0]  selReg,
  output logic [31:0]       busRdData,
  output logic [PINS*64-1:0] tableFlat,
  output logic              maskChgValid,
  output logic [IDX_W-1:0]  maskChgPin,
  output logic              maskChgValue,
  output logic              serviceValid,
  output logic [IDX_W-1:0]  servicePin
);
  localparam logic [7:0] PIN_TOP = 8'(PINS - 1);

  logic [3:0]       idReg;
  logic [63:0]      tblView [PINS];
  logic [IDX_W-1:0] idxN;
  logic [63:0]      curEntry;
  logic [63:0]      newEntry;
  logic [31:0]      rdNext;

  assign idxN     = strb.tblIdx[IDX_W-1:0];
  assign curEntry = tblView[idxN];

  // merge one half of the write data, keep hardware-owned bits
  always_comb begin
    newEntry = strb.tblHi ? {busWrData, curEntry[31:0]} : {curEntry[63:32], busWrData};
    newEntry[BIT_DLV]  = curEntry[BIT_DLV];
    newEntry[BIT_RIRR] = newEntry[BIT_TRIG] ? curEntry[BIT_RIRR] : 1'b0;
  end

  for (genvar i = 0; i < PINS; i++) begin : g_entry
    logic [63:0] ent;
    logic        wrHit;
    assign wrHit = strb.tblWr && (strb.tblIdx == TIDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        ent <= ENTRY_RESET;
      end else begin
        if (wrHit) begin
          ent <= newEntry;
        end else if (remIrrSet[i]) begin
          ent[BIT_RIRR] <= 1'b1;
        end else if (remIrrClr[i]) begin
          ent[BIT_RIRR] <= 1'b0;
        end
        ent[BIT_DLV] <= dlvBusy[i];
      end
    end

    assign tblView[i]           = ent;
    assign tableFlat[i*64 +: 64] = ent;

    // R10: reset leaves every entry masked
    assert_reset_mask_R10: assert property (@(posedge clk) disable iff (!rstN)
      $past(!rstN) |-> ent[BIT_MASK]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selReg <= '0;
      idReg  <= '0;
    end else begin
      if (strb.selWr) selReg <= busWrData[SEL_W-1:0];
      if (strb.idWr)  idReg  <= busWrData[27:24];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskChgValid <= 1'b0;
      maskChgPin   <= '0;
      maskChgValue <= 1'b0;
      serviceValid <= 1'b0;
      servicePin   <= '0;
    end else begin
      maskChgValid <= strb.tblWr && (newEntry[BIT_MASK] != curEntry[BIT_MASK]);
      maskChgPin   <= idxN;
      maskChgValue <= newEntry[BIT_MASK];
      serviceValid <= strb.tblWr && newEntry[BIT_TRIG] && pinRequest[idxN];
      servicePin   <= idxN;
    end
  end

  always_comb begin
    unique case (strb.rdKind)
      RD_SEL:  rdNext = 32'(selReg);
      RD_VER:  rdNext = {8'h00, PIN_TOP, 8'h00, VERSION};
      RD_ID:   rdNext = {4'h0, idReg, 24'h0};
      RD_TBL:  rdNext = strb.tblHi ? curEntry[63:32] : curEntry[31:0];
      RD_ONES: rdNext = '1;
      default: rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)             busRdData <= '0;
    else if (strb.rdLatch) busRdData <= rdNext;
  end

  // R8: the pulse reports the mask the table now holds
  assert_mask_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    maskChgValid |-> (tblView[maskChgPin][BIT_MASK] == maskChgValue));

  // R9: a service pulse only follows a write that left the entry level-triggered
  assert_service_level_R9: assert property (@(posedge clk) disable iff (!rstN)
    serviceValid |-> tblView[servicePin][BIT_TRIG]);

  // R7: a written entry left edge-triggered holds no remote IRR
  assert_edge_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.tblWr) |-> (tblView[$past(idxN)][BIT_TRIG] || !tblView[$past(idxN)][BIT_RIRR]));

  // R5: a read of a missing entry returns all ones
  assert_oor_ones_R5: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.rdLatch && strb.rdKind == RD_ONES) |-> (busRdData == 32'hFFFF_FFFF));

  // R12: read data holds when no read is requested
  assert_rd_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(strb.rdLatch) && $past(rstN)) |-> $stable(busRdData));
endmodule

// File: rtl/irq_regwin.sv
`timescale 1ns/1ps
module irq_regwin
  import irq_regwin_pkg::*;
#(
  parameter int unsigned PINS    = 24,
  parameter logic [7:0]  VERSION = 8'h11,
  localparam int unsigned IDX_W  = (PINS > 1) ? $clog2(PINS) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busWrEn,
  input  logic               busRdEn,
  input  logic [7:0]         busAddr,
  input  logic [31:0]        busWrData,
  output logic [31:0]        busRdData,
  input  logic [PINS-1:0]    pinRequest,
  input  logic [PINS-1:0]    remIrrSet,
  input  logic [PINS-1:0]    remIrrClr,
  input  logic [PINS-1:0]    dlvBusy,
  output logic [PINS*64-1:0] tableFlat,
  output logic               maskChgValid,
  output logic [IDX_W-1:0]   maskChgPin,
  output logic               maskChgValue,
  output logic               serviceValid,
  output logic [IDX_W-1:0]   servicePin
);
  strobes_t         strb;
  logic [SEL_W-1:0] selReg;

  irq_regwin_ctrl #(.PINS(PINS)) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .busAddr (busAddr),
    .selReg  (selReg),
    .strb    (strb)
  );

  irq_regwin_dp #(.PINS(PINS), .VERSION(VERSION)) i_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .busWrData    (busWrData),
    .pinRequest   (pinRequest),
    .remIrrSet    (remIrrSet),
    .remIrrClr    (remIrrClr),
    .dlvBusy      (dlvBusy),
    .selReg       (selReg),
    .busRdData    (busRdData),
    .tableFlat    (tableFlat),
    .maskChgValid (maskChgValid),
    .maskChgPin   (maskChgPin),
    .maskChgValue (maskChgValue),
    .serviceValid (serviceValid),
    .servicePin   (servicePin)
  );
endmodule

// File: tb/test_irq_regwin.sv
`timescale 1ns/1ps
module test_irq_regwin;
  localparam int PINS  = 24;
  localparam int IDX_W = $clog2(PINS);

  logic               clk = 1'b0;
  logic               rstN;
  logic               busWrEn, busRdEn;
  logic [7:0]         busAddr;
  logic [31:0]        busWrData;
  logic [31:0]        busRdData;
  logic [PINS-1:0]    pinRequest, remIrrSet, remIrrClr, dlvBusy;
  logic [PINS*64-1:0] tableFlat;
  logic               maskChgValid, maskChgValue, serviceValid;
  logic [IDX_W-1:0]   maskChgPin, servicePin;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic             gotMask, gotMaskVal, gotSvc;
  logic [IDX_W-1:0] gotMaskPin, gotSvcPin;

  always #2.5 clk = ~clk;

  irq_regwin #(.PINS(PINS)) i_irq_regwin (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .pinRequest(pinRequest), .remIrrSet(remIrrSet), .remIrrClr(remIrrClr),
    .dlvBusy(dlvBusy), .tableFlat(tableFlat),
    .maskChgValid(maskChgValid), .maskChgPin(maskChgPin), .maskChgValue(maskChgValue),
    .serviceValid(serviceValid), .servicePin(servicePin)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] addr, logic [31:0] data);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = addr; busWrData = data;
    @(negedge clk);
    busWrEn = 1'b0;
    gotMask = maskChgValid; gotMaskPin = maskChgPin; gotMaskVal = maskChgValue;
    gotSvc = serviceValid; gotSvcPin = servicePin;
  endtask

  task automatic rd(logic [7:0] addr, output logic [31:0] data);
    @(negedge clk);
    busRdEn = 1'b1; busAddr = addr;
    @(negedge clk);
    busRdEn = 1'b0;
    data = busRdData;
  endtask

  task automatic win_rd(logic [7:0] sel, output logic [31:0] data);
    wr(8'h00, 32'(sel));
    rd(8'h10, data);
  endtask

  task automatic win_wr(logic [7:0] sel, logic [31:0] data);
    wr(8'h00, 32'(sel));
    wr(8'h10, data);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    check("R10 rdData", 64'(busRdData), 64'h0);
    check("R10 mask pulse", 64'(maskChgValid), 64'h0);
    check("R10 service pulse", 64'(serviceValid), 64'h0);
    for (int p = 0; p < PINS; p++)
      check("R10 entry", tableFlat[p*64 +: 64], 64'h0000_0000_0001_0000);
    rd(8'h00, v);
    check("R10 index", 64'(v), 64'h0);
    rd(8'h10, v);
    check("R10 id", 64'(v), 64'h0);
    rd(8'h10 + 8'd0, v);
  endtask

  task automatic t_select;
    logic [31:0] v;
    wr(8'h00, 32'hABCD_1234);
    rd(8'h00, v);
    check("R1 index low byte", 64'(v), 64'h34);
  endtask

  task automatic t_version;
    logic [31:0] v;
    win_rd(8'h01, v);
    check("R2 version", 64'(v), 64'h0017_0011);
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, v);
    check("R2 write ignored", 64'(v), 64'h0017_0011);
  endtask

  task automatic t_id;
    logic [31:0] v;
    win_wr(8'h00, 32'h5A00_0000);
    rd(8'h10, v);
    check("R3 id write", 64'(v), 64'h0A00_0000);
    win_rd(8'h02, v);
    check("R3 arb alias", 64'(v), 64'h0A00_0000);
    wr(8'h10, 32'h0F00_0000);
    rd(8'h10, v);
    check("R3 arb write ignored", 64'(v), 64'h0A00_0000);
  endtask

  task automatic t_table;
    logic [31:0] v;
    win_wr(8'h16, 32'h0001_0045);
    check("R4 no mask pulse", 64'(gotMask), 64'h0);
    rd(8'h10, v);
    check("R4 low half", 64'(v), 64'h0001_0045);
    win_wr(8'h17, 32'hC500_0000);
    rd(8'h10, v);
    check("R4 high half", 64'(v), 64'hC500_0000);
    check("R4 table out", tableFlat[3*64 +: 64], 64'hC500_0000_0001_0045);
  endtask

  task automatic t_oor;
    logic [31:0]        v;
    logic [PINS*64-1:0] snap;
    win_rd(8'h40, v);
    check("R5 past pin count", 64'(v), 64'hFFFF_FFFF);
    win_rd(8'h05, v);
    check("R5 gap index", 64'(v), 64'hFFFF_FFFF);
    win_rd(8'h3F, v);
    check("R5 last pin high", 64'(v), 64'h0);
    snap = tableFlat;
    win_wr(8'h40, 32'h0000_0000);
    check("R5 no pulse", 64'({gotMask, gotSvc}), 64'h0);
    win_wr(8'hFF, 32'h0000_0000);
    win_wr(8'h05, 32'h0000_0000);
    check("R5 table untouched", 64'(tableFlat == snap), 64'h1);
  endtask

  task automatic t_status;
    logic [31:0] v;
    win_wr(8'h1A, 32'h0001_8030);
    @(negedge clk); remIrrSet[5] = 1'b1;
    @(negedge clk); remIrrSet[5] = 1'b0;
    rd(8'h10, v);
    check("R13 set strobe", 64'(v), 64'h0001_C030);
    wr(8'h10, 32'h0001_9030);
    rd(8'h10, v);
    check("R6 status kept", 64'(v), 64'h0001_C030);
    @(negedge clk); dlvBusy[5] = 1'b1;
    wr(8'h10, 32'h0001_8030);
    rd(8'h10, v);
    check("R6 busy kept", 64'(v), 64'h0001_D030);
    @(negedge clk); dlvBusy[5] = 1'b0;
    @(negedge clk); remIrrClr[5] = 1'b1;
    @(negedge clk); remIrrClr[5] = 1'b0;
    rd(8'h10, v);
    check("R13 clear strobe", 64'(v), 64'h0001_8030);
  endtask

  task automatic t_edge;
    logic [31:0] v;
    @(negedge clk); remIrrSet[5] = 1'b1;
    @(negedge clk); remIrrSet[5] = 1'b0;
    win_wr(8'h1B, 32'h1100_0000);
    win_rd(8'h1A, v);
    check("R7 level keeps remote irr", 64'(v), 64'h0001_C030);
    wr(8'h10, 32'h0001_4030);
    rd(8'h10, v);
    check("R7 edge clears remote irr", 64'(v), 64'h0001_0030);
  endtask

  task automatic t_mask;
    win_wr(8'h1E, 32'h0000_0050);
    check("R8 unmask pulse", 64'({gotMask, gotMaskVal}), 64'h2);
    check("R8 pin", 64'(gotMaskPin), 64'd7);
    wr(8'h10, 32'h0000_0050);
    check("R8 no pulse when unchanged", 64'(gotMask), 64'h0);
    wr(8'h10, 32'h0001_0050);
    check("R8 mask pulse", 64'({gotMask, gotMaskVal}), 64'h3);
    @(negedge clk);
    check("R8 one cycle", 64'(maskChgValid), 64'h0);
  endtask

  task automatic t_service;
    @(negedge clk); pinRequest[9] = 1'b1;
    win_wr(8'h22, 32'h0000_8060);
    check("R9 service pulse", 64'(gotSvc), 64'h1);
    check("R9 pin", 64'(gotSvcPin), 64'd9);
    @(negedge clk);
    check("R9 one cycle", 64'(serviceValid), 64'h0);
    wr(8'h10, 32'h0000_0060);
    check("R9 edge no service", 64'(gotSvc), 64'h0);
    @(negedge clk); pinRequest[9] = 1'b0;
    wr(8'h10, 32'h0000_8060);
    check("R9 no request no service", 64'(gotSvc), 64'h0);
  endtask

  task automatic t_offsets;
    logic [31:0] v;
    wr(8'h00, 32'h0000_0016);
    rd(8'h20, v);
    check("R11 other offset read", 64'(v), 64'h0);
    wr(8'h20, 32'h0000_0099);
    rd(8'h00, v);
    check("R11 other offset write", 64'(v), 64'h16);
  endtask

  task automatic t_hold;
    logic [31:0] v;
    rd(8'h00, v);
    wr(8'h00, 32'h0000_0001);
    repeat (2) @(negedge clk);
    check("R12 hold", 64'(busRdData), 64'h16);
    rd(8'h00, v);
    check("R12 update", 64'(v), 64'h01);
  endtask

  initial begin
    rstN = 1'b0; busWrEn = 1'b0; busRdEn = 1'b0; busAddr = '0; busWrData = '0;
    pinRequest = '0; remIrrSet = '0; remIrrClr = '0; dlvBusy = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset;
    t_select;
    t_version;
    t_id;
    t_table;
    t_oor;
    t_status;
    t_edge;
    t_mask;
    t_service;
    t_offsets;
    t_hold;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog (all R): actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule